// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the slave side of a two-wire serial bus in front of a 128-byte non-volatile array. It works from already-synchronized clock and data line samples taken on the system clock. From these it recognizes bus start and stop conditions, shifts bytes in on clock rising edges and shifts bytes out on clock falling edges. It pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero bit.

A master opens each transfer with a control byte. Its upper four bits must equal the device code. The next three bits are not compared, and the last bit selects read (1) or write (0). In a write, the first byte after the control byte sets a shared 7-bit address pointer. Every later byte is offered to an external page writer. When a stop ends a write that carried data, the block sends a commit pulse to the page writer. While the page writer reports that its program cycle is running, the block acknowledges nothing, so a master can poll it. Reads return the byte at the pointer and advance it. They continue for as long as the master acknowledges.

The page writer port follows a single-cycle valid/ready rule. `wr_valid` is high for exactly one system clock, on the falling SCL edge that ends a data byte. If `wr_ready` is high in that same cycle, the page writer takes the byte and the master gets an acknowledge. If `wr_ready` is low, the byte is refused: no acknowledge follows and the block ignores the bus until the next start. The block never holds a byte waiting for the page writer.

Top module: `twslv_engine`

## Requirements
- R1: SCL and SDA are both sampled on `clk`. A start is SDA going 1 to 0 while SCL stays high. A stop is SDA going 0 to 1 while SCL stays high. Data bits are taken only on SCL rising edges. Either condition releases SDA (`sda_oe`=0) by the next cycle. The block only begins pulling SDA low while SCL is low.
- R2: The control byte is sent most significant bit first. Bits 7:4 must equal 4'b1010, bits 3:1 are don't-care, and bit 0 is R/W (1 = read). If the code does not match, no acknowledge is given and every byte up to the next start is ignored.
- R3: An acknowledge pulls SDA low from the SCL falling edge after the eighth bit, through the ninth SCL high period. SDA is released on the next SCL falling edge.
- R4: While `pw_busy` is high, the control byte is not acknowledged.
- R5: In a write, the byte after the control byte is acknowledged. Its low 7 bits load the address pointer and its bit 7 is ignored.
- R6: Each later write byte is offered on `wr_valid` with `wr_addr` set to the pointer and `wr_data` set to the byte. It is acknowledged, and the pointer advances, only if `wr_ready` is high in that cycle. Otherwise it is not acknowledged and the block goes idle.
- R7: A stop after at least one accepted data byte gives a one-cycle `commit` pulse. A stop after only a control byte or an address byte gives none.
- R8: A read that starts straight after a control byte returns the byte at the pointer, that is, one past the last byte accessed.
- R9: A random read is an address-setting write, then a repeated start, then a read control byte. It returns the byte at the new address.
- R10: After a read byte, a master acknowledge makes the block send the next byte. The pointer wraps from 127 to 0. A master non-acknowledge makes the block release SDA and wait for a start.
- R11: A start in the middle of any byte abandons the transfer and begins control-byte reception again.
- R12: After reset, `sda_oe`, `wr_valid` and `commit` are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock sample |
| sda_i | input | 1 | Synchronized bus data sample |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rd_addr | output | 7 | Memory read address (the pointer) |
| rd_data | input | 8 | Memory read data, combinational from rd_addr |
| wr_valid | output | 1 | Data byte offered to the page writer (one cycle) |
| wr_ready | input | 1 | Page writer accepts the offered byte |
| wr_addr | output | 7 | Address of the offered byte |
| wr_data | output | 8 | Offered byte |
| commit | output | 1 | One-cycle pulse: start the program cycle |
| pw_busy | input | 1 | Page writer program cycle in progress |

## Verification
Some behaviours are checked on every cycle. After a start or stop, the data line must be released. The block must never begin pulling SDA low while SCL is high. Each page-writer handshake must be followed by an acknowledge when the byte is taken and by a release when it is refused. A commit must come only from a stop, for one cycle, and never together with an offered byte.

Other behaviours need whole bus transactions and only the bench scenarios show them. These are device-code matching with random don't-care bits, silence during busy polling, the shared pointer across current, random and sequential reads, the wrap at 127, aborts in the middle of a byte, and the memory contents after a commit.

// File: rtl/twslv_pkg.sv
package twslv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } st_e;
endpackage

// File: rtl/twslv_cond.sv
// Bus event detector: SCL edges and start/stop conditions (R1).
module twslv_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twslv_ptr.sv
// Shared read/write address pointer, wraps at 2**AW.
module twslv_ptr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/twslv_engine.sv
module twslv_engine
  import twslv_pkg::*;
#(
  parameter int                AW       = 7,
  parameter int                CODE_W   = 4,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [AW-1:0]     rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  input  logic              pw_busy
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  st_e              st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rd_mode, wrote, mack, commit_q;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic              byte_done, code_ok, rd_load, ptr_load, ptr_inc;
  logic [AW-1:0]     ptr;

  twslv_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  twslv_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(sh[AW-1:0]),
    .inc(ptr_inc), .ptr(ptr)
  );

  // R2: only the device code bits are compared; don't-care bits skipped.
  assign code_ok   = (sh[BYTE_W-1 -: CODE_W] == DEV_CODE);
  assign byte_done = scl_fall && (cnt == LAST_RX);
  // R8/R10: a byte is fetched when a read starts or the master acked.
  assign rd_load   = scl_fall && (((st == ST_CTRL_ACK) && rd_mode) ||
                                  ((st == ST_RACK) && mack));
  assign ptr_load  = (st == ST_ADDR) && byte_done;           // R5
  assign wr_valid  = (st == ST_WDATA) && byte_done;          // R6
  assign ptr_inc   = rd_load || (wr_valid && wr_ready);

  assign rd_addr = ptr;
  assign wr_addr = ptr;
  assign wr_data = sh;
  assign commit  = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sh       <= '0;
      cnt      <= '0;
      sda_oe   <= 1'b0;
      rd_mode  <= 1'b0;
      wrote    <= 1'b0;
      mack     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (stop_c) begin
        // R7: program only when data bytes were taken.
        commit_q <= wrote;
        wrote    <= 1'b0;
        sda_oe   <= 1'b0;
        st       <= ST_IDLE;
      end else if (start_c) begin
        // R11: any start restarts control-byte reception.
        wrote  <= 1'b0;
        sda_oe <= 1'b0;
        cnt    <= '0;
        st     <= ST_CTRL;
      end else begin
        unique case (st)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + CNT_W'(1);
            end else if (byte_done) begin
              cnt <= '0;
              if (st == ST_CTRL) begin
                if (code_ok && !pw_busy) begin     // R4
                  sda_oe  <= 1'b1;
                  rd_mode <= sh[0];
                  st      <= ST_CTRL_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_ADDR) begin
                sda_oe <= 1'b1;
                st     <= ST_ADDR_ACK;
              end else if (wr_ready) begin
                sda_oe <= 1'b1;
                wrote  <= 1'b1;
                st     <= ST_WDATA_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_CTRL_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;                    // R3 release
                st     <= ST_ADDR;
              end
            end
          end
          ST_ADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == LAST_TX) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
                cnt    <= cnt + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_i;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RDATA;
              end else begin
                st <= ST_IDLE;                     // R10 wait for start
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twslv_engine_chk.sv
module twslv_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic wr_valid,
  input logic wr_ready,
  input logic commit
);
  logic scl_p, sda_p;
  logic cond_seen, stop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  assign stop_seen = scl_i && scl_p && !sda_p && sda_i;
  assign cond_seen = scl_i && scl_p && (sda_p != sda_i);

  assert_release_on_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cond_seen |=> !sda_oe);

  assert_pull_only_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_ack_taken_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> sda_oe);

  assert_nack_refused_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> !sda_oe);

  assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_commit_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(stop_seen) && !wr_valid));
endmodule

bind twslv_engine twslv_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .commit(commit)
);

// File: tb/twslv_engine_bench.sv
module twslv_engine_bench;
  localparam int HALF = 4;
  localparam int BUSY = 200;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_valid, commit;
  logic wr_ready = 1'b1;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic pw_busy;
  logic sda_line;

  logic [7:0] dut_mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [6:0] pend_a [16];
  logic [7:0] pend_d [16];
  logic [3:0] pend_n;
  int busy_cnt;
  int commit_cnt;
  int exp_ptr;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = dut_mem[rd_addr];
  assign pw_busy  = (busy_cnt != 0);

  twslv_engine u_twslv_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit), .pw_busy(pw_busy)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // Page writer model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dut_mem[i] <= init_val(i);
      pend_n <= '0;
      busy_cnt <= 0;
      commit_cnt <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (wr_valid && wr_ready) begin
        pend_a[pend_n] <= wr_addr;
        pend_d[pend_n] <= wr_data;
        pend_n <= pend_n + 4'd1;
      end
      if (commit) begin
        for (int i = 0; i < 16; i++)
          if (i < int'(pend_n)) dut_mem[pend_a[i]] <= pend_d[i];
        pend_n <= '0;
        busy_cnt <= BUSY;
        commit_cnt <= commit_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(2);
    ack = ~sda_line;
    tick(HALF - 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl_m = 1'b1; tick(2);
      b[i] = sda_line;
      tick(HALF - 2);
      scl_m = 1'b0;
    end
    send_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (pw_busy) tick(1);
    tick(2);
  endtask

  function automatic logic [7:0] ctrl(input bit rd);
    logic [2:0] dc = 3'($urandom);
    return {4'b1010, dc, rd};
  endfunction

  // Write n bytes starting at a; R5/R6/R7
  task automatic do_write(input int a, input int n);
    bit ack;
    logic [7:0] d;
    int c0 = commit_cnt;
    bus_start();
    send_byte(ctrl(1'b0), ack);
    check(ack, "R2 write control ack", int'(ack), 1);
    send_byte({1'($urandom), 7'(a)}, ack);
    check(ack, "R5 address ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      check(ack, "R6 data ack", int'(ack), 1);
      exp_mem[(a + k) % DEPTH] = d;
    end
    bus_stop();
    tick(2);
    check(commit_cnt == c0 + 1, "R7 commit after data", commit_cnt - c0, 1);
    exp_ptr = (a + n) % DEPTH;
  endtask

  // Read n bytes; random read sets a first (R9), otherwise current (R8)
  task automatic do_read(input bit random, input int a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    int c0 = commit_cnt;
    bus_start();
    if (random) begin
      send_byte(ctrl(1'b0), ack);
      check(ack, "R9 set-address control ack", int'(ack), 1);
      send_byte(8'(a), ack);
      check(ack, "R9 address ack", int'(ack), 1);
      bus_start();
      exp_ptr = a;
    end
    send_byte(ctrl(1'b1), ack);
    check(ack, "R8 read control ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d == exp_mem[exp_ptr], req, int'(d), int'(exp_mem[exp_ptr]));
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    bus_stop();
    tick(2);
    check(commit_cnt == c0, "R7 no commit without data", commit_cnt - c0, 0);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    int c0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_val(i);
    exp_ptr = 0;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R12 reset state
    check(sda_oe == 1'b0, "R12 sda_oe after reset", int'(sda_oe), 0);
    check(wr_valid == 1'b0 && commit == 1'b0, "R12 outputs idle", int'(wr_valid | commit), 0);

    // R8 current read straight from reset pointer
    do_read(1'b0, 0, 2, "R8 current read data");

    // Write then busy polling (R4)
    do_write(20, 4);
    bus_start();
    send_byte(ctrl(1'b0), ack);
    check(!ack, "R4 no ack while busy", int'(ack), 0);
    bus_stop();
    wait_idle();
    bus_start();
    send_byte(ctrl(1'b0), ack);
    check(ack, "R4 ack once idle", int'(ack), 1);
    bus_stop();
    tick(2);

    // R8 current read after write: pointer = 24
    do_read(1'b0, 0, 1, "R8 current read after write");
    // R9 random read of written block
    do_read(1'b1, 20, 4, "R9 random read data");

    // R10 sequential wrap 126,127,0,1
    do_read(1'b1, 126, 4, "R10 wrap read data");
    check(exp_ptr == 2, "R10 pointer after wrap", exp_ptr, 2);
    do_read(1'b0, 0, 1, "R10 current read after wrap");

    // R2 wrong device code, then later bytes ignored
    bus_start();
    send_byte(8'b1011_0000, ack);
    check(!ack, "R2 wrong code nack", int'(ack), 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 bytes ignored after mismatch", int'(ack), 0);
    bus_stop();
    tick(2);
    do_read(1'b0, 0, 1, "R2 pointer untouched by mismatch");

    // R11 start in the middle of a byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(ctrl(1'b1), ack);
    check(ack, "R11 control after mid-byte start", int'(ack), 1);
    recv_byte(1'b0, d);
    check(d == exp_mem[exp_ptr], "R11 read after abort", int'(d), int'(exp_mem[exp_ptr]));
    exp_ptr = (exp_ptr + 1) % DEPTH;
    bus_stop();
    tick(2);

    // R6 back-pressure: refused data byte
    wr_ready = 1'b0;
    c0 = commit_cnt;
    bus_start();
    send_byte(ctrl(1'b0), ack);
    send_byte(8'd50, ack);
    check(ack, "R5 address ack under back-pressure", int'(ack), 1);
    send_byte(8'hA5, ack);
    check(!ack, "R6 refused byte nack", int'(ack), 0);
    send_byte(8'h5A, ack);
    check(!ack, "R6 idle after refusal", int'(ack), 0);
    bus_stop();
    tick(2);
    wr_ready = 1'b1;
    check(commit_cnt == c0, "R7 no commit after refusal", commit_cnt - c0, 0);
    exp_ptr = 50;
    do_read(1'b0, 0, 1, "R6 memory unchanged after refusal");

    // Random traffic (R5 R6 R8 R9 R10)
    for (int it = 0; it < 16; it++) begin
      int a = int'($urandom_range(0, DEPTH - 1));
      int n = int'($urandom_range(1, 8));
      wait_idle();
      do_write(a, n);
      wait_idle();
      do_read(1'b1, a, n, "R9 random-traffic readback");
      do_read(1'b0, 0, int'($urandom_range(1, 3)), "R10 random-traffic sequential");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule